// File: doc/BRIEF.md
# Shifted-Identity Message Address Generator

This block produces the memory addresses that a semi-parallel LDPC decoder uses to reach its banked message memories. The parity check matrix is a 3 by 6 grid of square sub-blocks. Each sub-block is an identity matrix rotated right by its own amount. Each sub-block's messages sit in a memory bank of their own. Several messages share one memory word, so a bank holds `P/PACK` words. The only matrix description kept in hardware is a table of 18 rotation amounts. A single word counter, plus those rotations modulo the bank depth, rebuilds every address, so no list of nonzero positions is stored anywhere.

A controller selects a half-iteration and a block index and pulses `start`.

- In the check half-iteration the block index picks a block row. The six banks of that row each receive their own stream: the counter plus that bank's rotation, wrapped to the bank depth.
- In the bit half-iteration the block index picks a block column. The three banks of that column all share one plain counter stream.

A pass walks every word of the selected banks once, one word per cycle, with no gaps. A flag marks the final word. A new pass may start in that final cycle and then follows with no idle cycle. Changing the block length changes only the counter width and the table field width.

Top module: `shid_addr_gen`

## Requirements
- R1: After reset `valid`, `done`, `bank_en` and `addr` are all zero, and every rotation in the table is zero.
- R2: An accepted `start` makes `valid` high from the next cycle for exactly `P/PACK` (32) consecutive cycles. In these cycles a word counter k runs 0, 1, … 31.
- R3: Check half-iteration (`phase`=0). `blk` = row r, which must be below 3. Banks b = r*6+c, for c = 0..5, are enabled in `bank_en`. Each of them outputs address (k + rot[b]) mod 32 in field `addr[5b+4:5b]`.
- R4: Bit half-iteration (`phase`=1). `blk` = column c, which must be below 6. Banks b = r*6+c, for r = 0..2, are enabled, and all of them output address k.
- R5: `done` is high only in the cycle where k = 31. In the following cycle `valid` is low, unless a new pass was accepted in that cycle.
- R6: A `start` given in the `done` cycle is accepted, and its first word appears in the very next cycle. A `start` in any other cycle with `valid` high is ignored and the running pass continues unchanged.
- R7: A table write puts `shift_val`/8 into rot[`shift_sel`], where `shift_sel` = row*6+col and `shift_val` is in message units 0..255. The write is ignored if `valid` is high, if `shift_sel` is 18 or more, or if `shift_val[2:0]` is not zero.
- R8: A `start` whose `blk` is out of range (3 or more in the check half-iteration, 6 or more in the bit half-iteration) is ignored. `valid` stays low.
- R9: Every bank not enabled in `bank_en` shows address zero in its `addr` field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_we | input | 1 | Rotation table write strobe |
| shift_sel | input | 5 | Table entry, row*6+col |
| shift_val | input | 8 | Rotation in messages, multiple of 8 |
| start | input | 1 | Begin a pass |
| phase | input | 1 | 0 = check half-iteration, 1 = bit half-iteration |
| blk | input | 3 | Block row (check) or block column (bit) |
| addr | output | 90 | One 5-bit word address per bank, bank b at bits 5b+4..5b |
| bank_en | output | 18 | Banks addressed this cycle |
| valid | output | 1 | Address outputs carry a pass word |
| done | output | 1 | Final word of the pass |

## Verification
Two events can fall in the same cycle: the end of a pass, marked by `done`, and the acceptance of a new `start`. The bench raises `start` with fresh parameters exactly in the `done` cycle. It then requires that the next cycle already carries word 0 of the new pass, with the new bank set and the new rotations, and that there is no idle cycle between the passes. It also raises `start` and table writes in the middle of a pass. In those cases the running stream must continue unchanged, and the next pass must show the old rotations.

// File: rtl/shid_addr_gen.sv
module shid_addr_gen #(
  parameter int P     = 256,
  parameter int PACK  = 8,
  parameter int ROWS  = 3,
  parameter int COLS  = 6
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   shift_we,
  input  logic [$clog2(ROWS*COLS)-1:0]           shift_sel,
  input  logic [$clog2(P)-1:0]                   shift_val,
  input  logic                                   start,
  input  logic                                   phase,
  input  logic [$clog2(COLS>ROWS?COLS:ROWS)-1:0] blk,
  output logic [ROWS*COLS*$clog2(P/PACK)-1:0]    addr,
  output logic [ROWS*COLS-1:0]                   bank_en,
  output logic                                   valid,
  output logic                                   done
);
  localparam int WORDS = P / PACK;
  localparam int AW    = $clog2(WORDS);
  localparam int SW    = $clog2(P);
  localparam int PW    = $clog2(PACK);
  localparam int NB    = ROWS * COLS;
  localparam int IW    = $clog2(NB);
  localparam int BLKW  = $clog2(COLS > ROWS ? COLS : ROWS);

  logic [AW-1:0]   rot [NB];
  logic            busy, ph;
  logic [AW-1:0]   cnt;
  logic [BLKW-1:0] sel;

  wire last     = busy && (cnt == AW'(WORDS-1));
  wire blk_ok   = phase ? (blk < BLKW'(COLS)) : (blk < BLKW'(ROWS));
  wire start_ok = start && blk_ok && (!busy || last);
  wire wr_ok    = shift_we && !busy && (shift_sel < IW'(NB)) &&
                  (shift_val[PW-1:0] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ph   <= 1'b0;
      cnt  <= '0;
      sel  <= '0;
    end else if (start_ok) begin
      busy <= 1'b1;
      ph   <= phase;
      cnt  <= '0;
      sel  <= blk;
    end else if (last) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt  <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) rot[i] <= '0;
    end else if (wr_ok) begin
      rot[shift_sel] <= shift_val[SW-1:PW];
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int B = r * COLS + c;
      wire hit = busy && (ph ? (sel == BLKW'(c)) : (sel == BLKW'(r)));
      assign bank_en[B]       = hit;
      assign addr[B*AW +: AW] = !hit ? '0 : (ph ? cnt : AW'(cnt + rot[B]));
    end
  end

  assign valid = busy;
  assign done  = last;

  AST_RESET_QUIET: assert property (@(posedge clk) $past(!rst_n) |-> !valid && !done) // R1
    else $error("valid after reset");
  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(valid) |-> $past(start)) // R2
    else $error("valid without start");
  AST_NO_GAP:      assert property (@(posedge clk) disable iff (!rst_n) (valid && !done) |=> valid) // R2
    else $error("gap in pass");
  AST_CHECK_BANKS: assert property (@(posedge clk) disable iff (!rst_n) (valid && !ph) |-> $countones(bank_en) == COLS) // R3
    else $error("check bank count");
  AST_BIT_BANKS:   assert property (@(posedge clk) disable iff (!rst_n) (valid && ph) |-> $countones(bank_en) == ROWS) // R4
    else $error("bit bank count");
  AST_DONE_VALID:  assert property (@(posedge clk) disable iff (!rst_n) done |-> valid) // R5
    else $error("done without valid");
  AST_DONE_END:    assert property (@(posedge clk) disable iff (!rst_n) (done && !start) |=> !valid) // R5
    else $error("pass overran");
  AST_IDLE_ZERO:   assert property (@(posedge clk) disable iff (!rst_n) !valid |-> (bank_en == '0 && addr == '0)) // R9
    else $error("idle outputs");
endmodule

// File: tb/tb_shid_addr_gen.sv
module tb_shid_addr_gen;
  localparam int NB = 18, AW = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic shift_we = 1'b0, start = 1'b0, phase = 1'b0;
  logic [4:0] shift_sel = '0;
  logic [7:0] shift_val = '0;
  logic [2:0] blk = '0;
  logic [NB*AW-1:0] addr;
  logic [NB-1:0] bank_en;
  logic valid, done;
  int checks = 0, fails = 0;
  int rot [NB];
  bit finished = 0;

  always #2.5 clk = ~clk;

  shid_addr_gen dut (.clk, .rst_n, .shift_we, .shift_sel, .shift_val,
                     .start, .phase, .blk, .addr, .bank_en, .valid, .done);

  function automatic logic [NB-1:0] exp_en(bit ph, int b);
    logic [NB-1:0] e = '0;
    for (int i = 0; i < NB; i++) e[i] = ph ? ((i % 6) == b) : ((i / 6) == b);
    return e;
  endfunction

  function automatic logic [NB*AW-1:0] exp_addr(bit ph, int b, int k);
    logic [NB*AW-1:0] a = '0;
    logic [NB-1:0] e = exp_en(ph, b);
    for (int i = 0; i < NB; i++)
      if (e[i]) a[i*AW +: AW] = ph ? AW'(k) : AW'((k + rot[i]) % 32);
    return a;
  endfunction

  task automatic chk(string req, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(int sel, int val);
    shift_we = 1; shift_sel = 5'(sel); shift_val = 8'(val);
    @(negedge clk); shift_we = 0;
  endtask

  task automatic check_word(bit ph, int b, int k, string req);
    chk(req, {valid, done, bank_en}, {1'b1, k == 31, exp_en(ph, b)});
    chk(req, addr, exp_addr(ph, b, k));
  endtask

  // full pass; mode 1: spurious start at k=10; mode 2: write at k=5
  task automatic pass(bit ph, int b, int mode, string req);
    phase = ph; blk = 3'(b); start = 1;
    @(negedge clk); start = 0;
    for (int k = 0; k < 32; k++) begin
      check_word(ph, b, k, req);
      if (mode == 1 && k == 10) begin start = 1; phase = ~ph; blk = 0; end
      if (mode == 2 && k == 5) begin shift_we = 1; shift_sel = 0; shift_val = 8'd64; end
      @(negedge clk); start = 0; shift_we = 0;
    end
    chk("R5", {valid, done}, 2'b00);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      fails++; $display("FAIL watchdog");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NB; i++) rot[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    chk("R1", {valid, done, bank_en, addr}, '0);
    pass(0, 1, 0, "R1_R3");

    wr(7, 248); rot[7] = 31;
    wr(8, 8);   rot[8] = 1;
    wr(9, 12);               // R7 misaligned, ignored
    wr(20, 16);              // R7 index out of range, ignored
    pass(0, 1, 0, "R7_R3");
    pass(1, 1, 0, "R4_R9");

    start = 1; phase = 0; blk = 3; @(negedge clk); start = 0;
    chk("R8", {valid, bank_en}, '0);
    start = 1; phase = 1; blk = 6; @(negedge clk); start = 0;
    chk("R8", {valid, bank_en}, '0);

    pass(0, 2, 1, "R6");
    pass(1, 0, 2, "R7");
    pass(1, 0, 0, "R7");      // write during the pass was dropped: rot[0] stays 0
    pass(0, 0, 0, "R7");

    // back-to-back: start in the done cycle
    phase = 0; blk = 1; start = 1; @(negedge clk); start = 0;
    for (int k = 0; k < 32; k++) begin
      check_word(0, 1, k, "R6");
      if (k == 31) begin start = 1; phase = 1; blk = 5; end
      @(negedge clk); start = 0;
    end
    for (int k = 0; k < 32; k++) begin
      check_word(1, 5, k, "R6_R4");
      @(negedge clk);
    end
    chk("R5", {valid, done}, 2'b00);

    for (int n = 0; n < 40; n++) begin
      int s = $urandom_range(NB - 1);
      int v = $urandom_range(31);
      bit ph;
      wr(s, v * 8); rot[s] = v;
      ph = 1'($urandom_range(1));
      pass(ph, ph ? $urandom_range(5) : $urandom_range(2), 0, ph ? "R4" : "R3");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule